// File: doc/BRIEF.md
# Watchdog Timer with Shared Timer Prescaler

This block is a watchdog timer that guards a small processor core. A base counter advances on a free-running watchdog tick and overflows after a fixed, parameterised number of ticks. One 8-bit prescaler is shared between the watchdog and a general-purpose Timer0. When the prescaler serves the watchdog, it stretches the time-out by acting as a postscaler behind the base counter. When it serves Timer0, it divides the Timer0 count source before that timer, and the watchdog then expires at its bare base period.

A control register selects which side owns the prescaler, sets the division ratio, and picks the Timer0 source: either the internal instruction-cycle strobe, or one chosen edge of an external pin. Software keeps the watchdog quiet with a clear command. A sleep command restarts the full period, so that a later expiry wakes the core instead of resetting it. A configuration bit enables the watchdog as a whole. The Timer0 counter itself lies outside this block, which only hands it a one-cycle increment pulse.

Top module: `wdog_prescale`

## Requirements
- R1: After reset the control register reads 8'hFF, so the prescaler is assigned to the watchdog at ratio 1:128. `wdt_rst`, `wake_rst`, `to_flag` and `t0_inc` are all low after reset.
- R2: With bit 3 (prescaler select) at 0, the watchdog raises `wdt_rst` for exactly one cycle, BASE_TICKS enabled ticks after its last clear, and then starts counting again.
- R3: With bit 3 at 1 and bits 2:0 equal to p, the time-out comes BASE_TICKS·2^p ticks after a clear.
- R4: A `clr_wdt` pulse restarts the base counter, and also the prescaler when it is assigned to the watchdog. No reset request follows in the cycle after the pulse.
- R5: A `sleep_cmd` pulse restarts the counters as `clr_wdt` does. The next time-out then raises `wake_rst` for one cycle instead of `wdt_rst`, and this ends the sleep state.
- R6: While `cfg_wdt_en` is low, the base counter holds its value and no reset request is produced.
- R7: `to_flag` is set by either reset request and cleared by `clr_wdt` or `sleep_cmd`.
- R8: With bit 3 at 0 and bit 5 (Timer0 source) at 0, `t0_inc` pulses one cycle after every 2^(p+1)-th `icyc_en` strobe.
- R9: With bit 3 at 0 and bit 5 at 1, Timer0 counts `t0_pin` edges. Bit 4 at 0 selects rising edges and bit 4 at 1 selects falling edges.
- R10: While bit 3 is 1, `t0_inc` stays low whatever the Timer0 sources do.
- R11: A control write that changes bit 3 clears the prescaler count. A write that leaves bit 3 unchanged keeps the count.
- R12: The control register stores all 8 written bits and returns them on `opt_q`. Bits 7:6 affect nothing in this block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wdt_tick | input | 1 | Watchdog time-base strobe |
| t0_pin | input | 1 | External Timer0 count pin |
| icyc_en | input | 1 | Instruction-cycle strobe |
| cfg_wdt_en | input | 1 | Configuration enable for the watchdog |
| opt_we | input | 1 | Control register write strobe |
| opt_wdata | input | 8 | Control register write data |
| clr_wdt | input | 1 | Clear-watchdog command |
| sleep_cmd | input | 1 | Sleep command |
| wdt_rst | output | 1 | One-cycle time-out reset request |
| wake_rst | output | 1 | One-cycle wake-up reset request |
| to_flag | output | 1 | Time-out status |
| t0_inc | output | 1 | Scaled increment pulse to Timer0 |
| opt_q | output | 8 | Control register contents |

## Verification
Every result is registered once. A reset request, `to_flag` and `t0_inc` all appear one clock after the edge that consumed the final tick, strobe or pin edge. The bench drives inputs at the falling edge and samples outputs at the next falling edge. This makes a time-out count exactly BASE_TICKS·2^p samples after the clear pulse is released, and puts each Timer0 pulse at the sample that closes the strobe or pin transition that caused it. The control write and the clear commands each take effect at the edge they are presented on. Their effects are therefore checked at the sample right after they are withdrawn.

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int BASE_TICKS = 18
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wdt_tick,
  input  logic       t0_pin,
  input  logic       icyc_en,
  input  logic       cfg_wdt_en,
  input  logic       opt_we,
  input  logic [7:0] opt_wdata,
  input  logic       clr_wdt,
  input  logic       sleep_cmd,
  output logic       wdt_rst,
  output logic       wake_rst,
  output logic       to_flag,
  output logic       t0_inc,
  output logic [7:0] opt_q
);
  localparam int CW = $clog2(BASE_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(BASE_TICKS - 1);

  logic [CW-1:0] wcnt;
  logic [7:0]    psc;
  logic          pin_q, asleep;

  wire       psa  = opt_q[3];
  wire       t0cs = opt_q[5];
  wire       t0se = opt_q[4];
  wire [2:0] ps   = opt_q[2:0];

  wire wclr    = clr_wdt | sleep_cmd;
  wire wstep   = cfg_wdt_en & wdt_tick & ~wclr;
  wire base_ov = wstep & (wcnt == LAST);

  wire pin_edge = t0se ? (pin_q & ~t0_pin) : (t0_pin & ~pin_q);
  wire t0_ev    = t0cs ? pin_edge : icyc_en;
  wire ev       = psa ? base_ov : t0_ev;

  wire [3:0] k    = psa ? {1'b0, ps} : {1'b0, ps} + 4'd1;
  wire [7:0] mask = 8'hFF >> (4'd8 - k);
  wire       fire = ev & ((psc & mask) == mask);

  wire timeout = psa ? fire : base_ov;
  wire psa_chg = opt_we & (opt_wdata[3] != psa);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opt_q    <= 8'hFF;
      wcnt     <= '0;
      psc      <= '0;
      pin_q    <= 1'b0;
      asleep   <= 1'b0;
      wdt_rst  <= 1'b0;
      wake_rst <= 1'b0;
      to_flag  <= 1'b0;
      t0_inc   <= 1'b0;
    end else begin
      pin_q <= t0_pin;
      if (opt_we) opt_q <= opt_wdata;

      if (wclr)       wcnt <= '0;
      else if (wstep) wcnt <= base_ov ? '0 : wcnt + 1'b1;

      if (psa_chg || (wclr && psa)) psc <= '0;
      else if (ev)                  psc <= psc + 8'd1;

      wdt_rst  <= timeout & ~asleep;
      wake_rst <= timeout & asleep;
      t0_inc   <= fire & ~psa;

      if (sleep_cmd)              asleep <= 1'b1;
      else if (timeout && asleep) asleep <= 1'b0;

      if (timeout)   to_flag <= 1'b1;
      else if (wclr) to_flag <= 1'b0;
    end
  end

  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt < CW'(BASE_TICKS));
  assert_clr_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wdt |=> !(wdt_rst || wake_rst));
  assert_sleep_no_rst_R5: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> !wdt_rst);
  assert_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wdt_rst && wake_rst));
  assert_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wdt_en |=> !(wdt_rst || wake_rst));
  assert_flag_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(to_flag) |-> (wdt_rst || wake_rst));
  assert_t0_owner_R10: assert property (@(posedge clk) disable iff (!rst_n)
    psa |=> !t0_inc);
endmodule

// File: tb/wdog_prescale_tb.sv
module wdog_prescale_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BASE = 18;

  logic clk = 0, rst_n = 0;
  logic wdt_tick = 0, t0_pin = 0, icyc_en = 0, cfg_wdt_en = 0;
  logic opt_we = 0, clr_wdt = 0, sleep_cmd = 0;
  logic [7:0] opt_wdata = 8'h00;
  logic wdt_rst, wake_rst, to_flag, t0_inc;
  logic [7:0] opt_q;
  int checks = 0, errors = 0;

  wdog_prescale #(.BASE_TICKS(BASE)) u_dut (
    .clk(clk), .rst_n(rst_n), .wdt_tick(wdt_tick), .t0_pin(t0_pin),
    .icyc_en(icyc_en), .cfg_wdt_en(cfg_wdt_en), .opt_we(opt_we),
    .opt_wdata(opt_wdata), .clr_wdt(clr_wdt), .sleep_cmd(sleep_cmd),
    .wdt_rst(wdt_rst), .wake_rst(wake_rst), .to_flag(to_flag),
    .t0_inc(t0_inc), .opt_q(opt_q));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic write_opt(input logic [7:0] v);
    @(negedge clk); opt_we = 1; opt_wdata = v;
    @(negedge clk); opt_we = 0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr_wdt = 1;
    @(negedge clk); clr_wdt = 0;
  endtask

  task automatic pulse_sleep();
    @(negedge clk); sleep_cmd = 1;
    @(negedge clk); sleep_cmd = 0;
  endtask

  task automatic count_to_req(output int n, output int rst_seen, output int wake_seen);
    n = 0; rst_seen = 0; wake_seen = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk); n++;
      if (wdt_rst || wake_rst) begin
        rst_seen = int'(wdt_rst); wake_seen = int'(wake_rst);
        break;
      end
    end
  endtask

  task automatic quiet_for(input int cyc, input string tag);
    int bad = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (wdt_rst || wake_rst) bad++;
    end
    check(tag, bad, 0);
  endtask

  task automatic strobe(output int got);
    @(negedge clk); icyc_en = 1;
    @(negedge clk); icyc_en = 0;
    got = int'(t0_inc);
  endtask

  task automatic test_reset();
    int n, r, w;
    check("R1 opt_q", int'(opt_q), 255);
    check("R1 wdt_rst", int'(wdt_rst), 0);
    check("R1 wake_rst", int'(wake_rst), 0);
    check("R1 to_flag", int'(to_flag), 0);
    check("R1 t0_inc", int'(t0_inc), 0);
    count_to_req(n, r, w);
    check("R3 default 1:128 period", n, BASE * 128);
    check("R3 default reset kind", r, 1);
    @(negedge clk);
    check("R2 one-cycle pulse", int'(wdt_rst), 0);
    check("R7 flag set by timeout", int'(to_flag), 1);
  endtask

  task automatic test_direct();
    int n, r, w;
    write_opt(8'hF7);
    pulse_clr();
    check("R7 flag cleared by clr", int'(to_flag), 0);
    count_to_req(n, r, w);
    check("R2 base period", n, BASE);
    check("R2 reset kind", r, 1);
    count_to_req(n, r, w);
    check("R2 restarted period", n, BASE);
  endtask

  task automatic test_postscale();
    int n, r, w;
    int plist[3] = '{0, 2, 4};
    foreach (plist[j]) begin
      write_opt(8'hF8 | 8'(plist[j]));
      pulse_clr();
      count_to_req(n, r, w);
      check($sformatf("R3 period p=%0d", plist[j]), n, BASE << plist[j]);
    end
  endtask

  task automatic test_clear();
    int n, r, w;
    write_opt(8'hFA);
    pulse_clr();
    quiet_for(3 * BASE, "R4 no reset before clear");
    pulse_clr();
    count_to_req(n, r, w);
    check("R4 full period after clear", n, 4 * BASE);
  endtask

  task automatic test_sleep();
    int n, r, w;
    write_opt(8'hF9);
    pulse_clr();
    quiet_for(BASE + 5, "R5 awake wait");
    pulse_sleep();
    check("R7 flag cleared by sleep", int'(to_flag), 0);
    count_to_req(n, r, w);
    check("R5 sleep full period", n, 2 * BASE);
    check("R5 wake request", w, 1);
    check("R5 no reset while asleep", r, 0);
    @(negedge clk);
    check("R5 wake one cycle", int'(wake_rst), 0);
    check("R7 flag set by wake", int'(to_flag), 1);
    count_to_req(n, r, w);
    check("R5 awake after wake", r, 1);
  endtask

  task automatic test_disable();
    int n, r, w;
    write_opt(8'hF7);
    @(negedge clk); cfg_wdt_en = 0;
    pulse_clr();
    quiet_for(3 * BASE, "R6 disabled no reset");
    cfg_wdt_en = 1;
    count_to_req(n, r, w);
    check("R6 counter held then full period", n, BASE);
  endtask

  task automatic test_t0_internal();
    int got;
    cfg_wdt_en = 0; wdt_tick = 0;
    write_opt(8'hFF);
    write_opt(8'hD1);
    for (int i = 0; i < 12; i++) begin
      strobe(got);
      check($sformatf("R8 strobe %0d", i), got, (i % 4 == 3) ? 1 : 0);
    end
  endtask

  task automatic pin_run(input logic [7:0] v, output int rise_p, output int fall_p);
    write_opt(8'hFF);
    write_opt(v);
    rise_p = 0; fall_p = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); t0_pin = ~t0_pin;
      @(negedge clk);
      if (t0_inc) begin
        if (t0_pin) rise_p++; else fall_p++;
      end
    end
  endtask

  task automatic test_t0_pin();
    int rp, fp;
    t0_pin = 0;
    pin_run(8'hE0, rp, fp);
    check("R9 rising edge pulses", rp, 2);
    check("R9 no falling pulses", fp, 0);
    pin_run(8'hF0, rp, fp);
    check("R9 falling edge pulses", fp, 2);
    check("R9 no rising pulses", rp, 0);
  endtask

  task automatic test_owner();
    int got, seen = 0;
    write_opt(8'hFF);
    for (int i = 0; i < 8; i++) begin
      strobe(got); seen += got;
      @(negedge clk); t0_pin = ~t0_pin;
      @(negedge clk); seen += int'(t0_inc);
    end
    check("R10 t0_inc low while watchdog owns prescaler", seen, 0);
  endtask

  task automatic test_psa_write();
    int got;
    write_opt(8'hD1);
    strobe(got); strobe(got);
    write_opt(8'hD1);
    strobe(got);
    check("R11 kept count no early pulse", got, 0);
    strobe(got);
    check("R11 kept count pulse on 4th", got, 1);
    strobe(got); strobe(got);
    write_opt(8'hFF);
    write_opt(8'hD1);
    for (int i = 0; i < 3; i++) begin
      strobe(got);
      check("R11 cleared count no pulse", got, 0);
    end
    strobe(got);
    check("R11 cleared count pulse", got, 1);
  endtask

  task automatic test_readback();
    write_opt(8'h25);
    check("R12 readback", int'(opt_q), 8'h25);
    write_opt(8'h3F);
    check("R12 readback high bits", int'(opt_q), 8'h3F);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, -1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wdt_tick = 1; cfg_wdt_en = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    test_reset();
    test_direct();
    test_postscale();
    test_clear();
    test_sleep();
    test_disable();
    test_t0_internal();
    test_t0_pin();
    test_owner();
    test_psa_write();
    test_readback();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule